// File: doc/BRIEF.md
# Palette Colour Lookup Table

This block converts an 8-bit pixel index into an 18-bit colour, with 6 bits each for red, green and blue. The table holds 256 entries. On the pixel side, the incoming index is first ANDed with a programmable mask. The masked index then reads the table, and the result is registered, so each colour appears one clock after its index.

Software reaches the table through a byte-wide host port that has four selectable registers: a write-entry register, a data register, the pixel mask and a read-entry register.

- **Writing an entry.** Software loads the write-entry register, then writes red, green and blue bytes in turn to the data register. Each byte keeps only its upper six bits. The block counts which component comes next. After blue, it stores the whole colour at once and steps to the next entry.
- **Reading entries back.** Software loads the read-entry register, then reads the data register three times per entry. It gets red, green and blue in that order, and then the read pointer steps on. The read pointer and its component count are separate from those used for writing.

Top module: `palette_lut`

## Requirements
- R1: After reset, `pix_rgb` and `host_rdata` are 0, the mask is 0xFF, and both entry pointers and both component counts are 0.
- R2: A host write with `host_sel`=0 loads the write pointer from `host_wdata`. It restarts the component count at red and discards any red or green already received.
- R3: Host writes with `host_sel`=1 supply red, then green, then blue. Each component stores `host_wdata[7:2]`. In the 18-bit colour, red is bits 17:12, green is bits 11:6 and blue is bits 5:0.
- R4: An entry changes only when its blue byte is written. After only red, or red and green, a lookup of that entry still shows its previous colour.
- R5: After the blue write, the write pointer increments by 1 and wraps from 255 to 0.
- R6: A host write with `host_sel`=2 loads the mask. The lookup address is `pix_idx & mask`. A host read with `host_sel`=2 returns the mask.
- R7: The colour for the index sampled at clock edge k appears on `pix_rgb` after edge k. When a blue write is sampled at the same edge k, a lookup sampled at edge k returns the old colour and one sampled at edge k+1 returns the new one.
- R8: A host write with `host_sel`=3 loads the read pointer and restarts its count at red. Each host read with `host_sel`=1 returns the current component as `{value, 2'b00}` on `host_rdata` after that edge. After blue, the read pointer increments by 1 and wraps from 255 to 0.
- R9: `host_rd_en` is ignored while `host_wr_en` is high. `host_rdata` holds its value on any edge that has no accepted read. Reads with `host_sel`=0 or `host_sel`=3 return 0.
- R10: Writing and reading through the data register advance independent pointers. An entry read-back placed between the red and blue writes neither disturbs the pending write nor is disturbed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_sel | input | 2 | Register select: 0 write-entry, 1 data, 2 mask, 3 read-entry |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| pix_idx | input | 8 | Pixel colour index |
| pix_rgb | output | 18 | Registered colour {red, green, blue} |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it:

- a host read appears on `host_rdata`;
- a pixel index appears on `pix_rgb`;
- a committed colour is visible to a lookup sampled at the edge after the commit.

The bench drives its inputs on falling edges. A behavioural model updates on each rising edge, from the inputs sampled there, and the ports are compared with the model on the next falling edge. Directed checks are timed the same way; one places the pixel probe on the commit edge itself, to confirm that the old colour is seen there and the new one a cycle later.

// File: rtl/palette_pkg.sv
package palette_pkg;
    localparam int PAL_IDX_W  = 8;
    localparam int PAL_COMP_W = 6;
    localparam int PAL_BYTE_W = 8;
    localparam int PAL_NCOMP  = 3;

    typedef enum logic [1:0] {
        SEL_WIDX = 2'd0,
        SEL_DATA = 2'd1,
        SEL_MASK = 2'd2,
        SEL_RIDX = 2'd3
    } host_sel_e;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } comp_phase_e;
endpackage

// File: rtl/palette_wr_seq.sv
module palette_wr_seq
    import palette_pkg::*;
#(
    parameter int IDX_W  = PAL_IDX_W,
    parameter int COMP_W = PAL_COMP_W,
    localparam int RGB_W = COMP_W * PAL_NCOMP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [IDX_W-1:0]  load_idx_i,
    input  logic              data_we_i,
    input  logic [COMP_W-1:0] data_i,
    output logic              commit_o,
    output logic [IDX_W-1:0]  commit_addr_o,
    output logic [RGB_W-1:0]  commit_rgb_o
);
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        comp_phase_e       phase;
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] green;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic      commit_d;

    always_comb begin
        s_d      = s_q;
        commit_d = 1'b0;
        if (load_i) begin
            s_d.idx   = load_idx_i;
            s_d.phase = PH_RED;
        end else if (data_we_i) begin
            case (s_q.phase)
                PH_RED: begin
                    s_d.red   = data_i;
                    s_d.phase = PH_GREEN;
                end
                PH_GREEN: begin
                    s_d.green = data_i;
                    s_d.phase = PH_BLUE;
                end
                PH_BLUE: begin
                    commit_d  = 1'b1;
                    s_d.idx   = s_q.idx + IDX_W'(1);
                    s_d.phase = PH_RED;
                end
                default: s_d.phase = PH_RED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{idx: '0, phase: PH_RED, red: '0, green: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign commit_o      = commit_d;
    assign commit_addr_o = s_q.idx;
    assign commit_rgb_o  = {s_q.red, s_q.green, data_i};

    // R5: pointer steps by one (wrapping) after each committed entry
    a_r5_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> s_q.idx == IDX_W'($past(s_q.idx) + IDX_W'(1)));
    // R2: loading the entry pointer restarts at red
    a_r2_load_phase: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> s_q.phase == PH_RED);
    // R3: the component count never leaves red/green/blue
    a_r3_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase != 2'd3);
    // R4: no commit unless a data write occurred
    a_r4_commit_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> data_we_i && !load_i);
endmodule

// File: rtl/palette_rd_seq.sv
module palette_rd_seq
    import palette_pkg::*;
#(
    parameter int IDX_W = PAL_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] load_idx_i,
    input  logic             rd_i,
    output logic [IDX_W-1:0] ptr_o,
    output comp_phase_e      phase_o
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        comp_phase_e      phase;
    } rd_state_t;

    rd_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.ptr   = load_idx_i;
            s_d.phase = PH_RED;
        end else if (rd_i) begin
            case (s_q.phase)
                PH_RED:   s_d.phase = PH_GREEN;
                PH_GREEN: s_d.phase = PH_BLUE;
                PH_BLUE: begin
                    s_d.ptr   = s_q.ptr + IDX_W'(1);
                    s_d.phase = PH_RED;
                end
                default:  s_d.phase = PH_RED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ptr: '0, phase: PH_RED};
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr_o   = s_q.ptr;
    assign phase_o = s_q.phase;

    // R8: read pointer advances only after the blue read
    a_r8_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i && s_q.phase == PH_BLUE) |=> s_q.ptr == IDX_W'($past(s_q.ptr) + IDX_W'(1)));
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !load_i) |=> $stable(s_q));
endmodule

// File: rtl/palette_store.sv
module palette_store
    import palette_pkg::*;
#(
    parameter int IDX_W  = PAL_IDX_W,
    parameter int COMP_W = PAL_COMP_W,
    localparam int RGB_W   = COMP_W * PAL_NCOMP,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [RGB_W-1:0] wdata_i,
    input  logic [IDX_W-1:0] host_addr_i,
    output logic [RGB_W-1:0] host_rgb_o,
    input  logic [IDX_W-1:0] pix_addr_i,
    output logic [RGB_W-1:0] pix_rgb_o
);
    logic [RGB_W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign host_rgb_o = mem_q[host_addr_i];
    assign pix_rgb_o  = mem_q[pix_addr_i];
endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import palette_pkg::*;
#(
    parameter int IDX_W  = PAL_IDX_W,
    parameter int COMP_W = PAL_COMP_W,
    parameter int BYTE_W = PAL_BYTE_W,
    localparam int RGB_W = COMP_W * PAL_NCOMP,
    localparam int PAD_W = BYTE_W - COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [1:0]        host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb
);
    typedef struct packed {
        logic [IDX_W-1:0]  mask;
        logic [RGB_W-1:0]  rgb;
        logic [BYTE_W-1:0] rdata;
    } top_state_t;

    top_state_t s_d, s_q;

    // host decode: a write takes the port, a read needs a free cycle
    logic rd_ok;
    logic widx_load, data_we, mask_we, ridx_load, data_rd;
    assign rd_ok     = host_rd_en && !host_wr_en;
    assign widx_load = host_wr_en && (host_sel == SEL_WIDX);
    assign data_we   = host_wr_en && (host_sel == SEL_DATA);
    assign mask_we   = host_wr_en && (host_sel == SEL_MASK);
    assign ridx_load = host_wr_en && (host_sel == SEL_RIDX);
    assign data_rd   = rd_ok && (host_sel == SEL_DATA);

    logic              commit;
    logic [IDX_W-1:0]  commit_addr;
    logic [RGB_W-1:0]  commit_rgb;
    logic [IDX_W-1:0]  rd_ptr;
    comp_phase_e       rd_phase;
    logic [RGB_W-1:0]  host_rgb;
    logic [RGB_W-1:0]  look_rgb;
    logic [IDX_W-1:0]  look_addr;

    palette_wr_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_wr_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (widx_load),
        .load_idx_i    (host_wdata[IDX_W-1:0]),
        .data_we_i     (data_we),
        .data_i        (host_wdata[BYTE_W-1 -: COMP_W]),
        .commit_o      (commit),
        .commit_addr_o (commit_addr),
        .commit_rgb_o  (commit_rgb)
    );

    palette_rd_seq #(.IDX_W(IDX_W)) u_rd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ridx_load),
        .load_idx_i (host_wdata[IDX_W-1:0]),
        .rd_i       (data_rd),
        .ptr_o      (rd_ptr),
        .phase_o    (rd_phase)
    );

    assign look_addr = pix_idx & s_q.mask;

    palette_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
        .clk         (clk),
        .we_i        (commit),
        .waddr_i     (commit_addr),
        .wdata_i     (commit_rgb),
        .host_addr_i (rd_ptr),
        .host_rgb_o  (host_rgb),
        .pix_addr_i  (look_addr),
        .pix_rgb_o   (look_rgb)
    );

    // split the stored colour into components, red in the top field
    logic [COMP_W-1:0] comp_of [PAL_NCOMP];
    for (genvar g = 0; g < PAL_NCOMP; g++) begin : g_split
        assign comp_of[g] = host_rgb[(PAL_NCOMP-1-g)*COMP_W +: COMP_W];
    end

    logic [COMP_W-1:0] rd_comp;
    always_comb begin
        case (rd_phase)
            PH_RED:   rd_comp = comp_of[0];
            PH_GREEN: rd_comp = comp_of[1];
            PH_BLUE:  rd_comp = comp_of[2];
            default:  rd_comp = '0;
        endcase
    end

    always_comb begin
        s_d     = s_q;
        s_d.rgb = look_rgb;
        if (mask_we) begin
            s_d.mask = host_wdata[IDX_W-1:0];
        end
        if (rd_ok) begin
            case (host_sel)
                SEL_DATA: s_d.rdata = {rd_comp, {PAD_W{1'b0}}};
                SEL_MASK: s_d.rdata = BYTE_W'(s_q.mask);
                default:  s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{mask: '1, rgb: '0, rdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign host_rdata = s_q.rdata;
    assign pix_rgb    = s_q.rgb;

    // R6: mask register takes the written byte
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> s_q.mask == $past(host_wdata[IDX_W-1:0]));
    // R9: read data holds when no read is accepted
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd_en && !host_wr_en) |=> $stable(host_rdata));
    // R8: a data read returns a byte whose low pad bits are zero
    a_r8_rdata_pad: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> host_rdata[PAD_W-1:0] == '0);
    // R6: mask holds without a mask write
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(s_q.mask));
endmodule

// File: tb/palette_lut_bench.sv
module palette_lut_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_rd_en = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic [7:0]  pix_idx = 8'd0;
    logic [17:0] pix_rgb;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    palette_lut u_palette_lut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_rd_en (host_rd_en),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pix_idx    (pix_idx),
        .pix_rgb    (pix_rgb)
    );

    // behavioural reference model
    int m_tab [256];
    bit m_ok  [256];
    int m_widx, m_wph, m_r, m_g, m_ridx, m_rph, m_mask;
    int exp_pix, exp_rd;
    bit exp_pix_ok, exp_rd_ok;

    initial begin
        for (int i = 0; i < 256; i++) begin m_tab[i] = 0; m_ok[i] = 0; end
    end

    always @(posedge clk) begin
        int a;
        if (!rst_n) begin
            m_widx = 0; m_wph = 0; m_r = 0; m_g = 0;
            m_ridx = 0; m_rph = 0; m_mask = 255;
            exp_pix = 0; exp_pix_ok = 1; exp_rd = 0; exp_rd_ok = 1;
        end else begin
            a = int'(pix_idx) & m_mask;
            exp_pix = m_tab[a]; exp_pix_ok = m_ok[a];
            if (host_wr_en) begin
                case (host_sel)
                    2'd0: begin m_widx = host_wdata; m_wph = 0; end
                    2'd1: begin
                        if (m_wph == 0) begin m_r = host_wdata >> 2; m_wph = 1; end
                        else if (m_wph == 1) begin m_g = host_wdata >> 2; m_wph = 2; end
                        else begin
                            m_tab[m_widx] = (m_r << 12) | (m_g << 6) | (host_wdata >> 2);
                            m_ok[m_widx] = 1;
                            m_widx = (m_widx + 1) % 256; m_wph = 0;
                        end
                    end
                    2'd2: m_mask = host_wdata;
                    default: begin m_ridx = host_wdata; m_rph = 0; end
                endcase
            end else if (host_rd_en) begin
                case (host_sel)
                    2'd1: begin
                        exp_rd = ((m_tab[m_ridx] >> (6 * (2 - m_rph))) & 63) << 2;
                        exp_rd_ok = m_ok[m_ridx];
                        if (m_rph == 2) begin m_rph = 0; m_ridx = (m_ridx + 1) % 256; end
                        else m_rph = m_rph + 1;
                    end
                    2'd2: begin exp_rd = m_mask; exp_rd_ok = 1; end
                    default: begin exp_rd = 0; exp_rd_ok = 1; end
                endcase
            end
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_pix_ok) begin
                n_chk++;
                if (int'(pix_rgb) != exp_pix) begin
                    n_bad++;
                    $display("FAIL R7 model pix_rgb actual=%h expected=%h", pix_rgb, exp_pix);
                end
            end
            if (exp_rd_ok) begin
                n_chk++;
                if (int'(host_rdata) != exp_rd) begin
                    n_bad++;
                    $display("FAIL R8 model host_rdata actual=%h expected=%h", host_rdata, exp_rd);
                end
            end
        end
    end

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input bit w, input bit r, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        host_wr_en = w; host_rd_en = r; host_sel = s; host_wdata = d;
    endtask

    task automatic idle();
        drive(0, 0, 2'd0, 8'd0);
    endtask

    function automatic int fill_rgb(input int i);
        return ((i >> 2) << 12) | (((255 - i) >> 2) << 6) | (((i * 37) & 255) >> 2);
    endfunction

    function automatic int rgb_of(input int r, input int g, input int b);
        return ((r >> 2) << 12) | ((g >> 2) << 6) | (b >> 2);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(pix_rgb), 0, "R1 reset pix_rgb");
        chk(int'(host_rdata), 0, "R1 reset host_rdata");
        drive(0, 1, 2'd2, 8'd0); idle();
        chk(int'(host_rdata), 255, "R1 reset mask");

        // fill every entry from index 0
        drive(1, 0, 2'd0, 8'd0);
        for (int i = 0; i < 256; i++) begin
            drive(1, 0, 2'd1, 8'(i));
            drive(1, 0, 2'd1, 8'(255 - i));
            drive(1, 0, 2'd1, 8'((i * 37) & 255));
        end
        idle();
        pix_idx = 8'd77; idle(); idle();
        chk(int'(pix_rgb), fill_rgb(77), "R3 filled entry 77");

        // R5: pointer wrapped to 0 after entry 255
        drive(1, 0, 2'd1, 8'hFC); drive(1, 0, 2'd1, 8'h00); drive(1, 0, 2'd1, 8'h80);
        pix_idx = 8'd0; idle(); idle();
        chk(int'(pix_rgb), rgb_of(252, 0, 128), "R5 wrap to entry 0");

        // R4: partial write invisible; R2: reload discards it
        pix_idx = 8'd5;
        drive(1, 0, 2'd0, 8'd5); drive(1, 0, 2'd1, 8'h00); drive(1, 0, 2'd1, 8'h00);
        idle(); idle();
        chk(int'(pix_rgb), fill_rgb(5), "R4 partial not shown");
        drive(1, 0, 2'd0, 8'd5);
        drive(1, 0, 2'd1, 8'h40); drive(1, 0, 2'd1, 8'h80); drive(1, 0, 2'd1, 8'hC0);
        idle(); idle();
        chk(int'(pix_rgb), rgb_of(64, 128, 192), "R2 reload restarts at red");

        // R7: commit edge timing
        pix_idx = 8'd9;
        drive(1, 0, 2'd0, 8'd9);
        drive(1, 0, 2'd1, 8'h10); drive(1, 0, 2'd1, 8'h20); drive(1, 0, 2'd1, 8'h30);
        idle();
        chk(int'(pix_rgb), fill_rgb(9), "R7 lookup on commit edge sees old");
        idle();
        chk(int'(pix_rgb), rgb_of(16, 32, 48), "R7 next lookup sees new");

        // R6: mask
        drive(1, 0, 2'd2, 8'h0F);
        pix_idx = 8'hF5; idle(); idle();
        chk(int'(pix_rgb), rgb_of(64, 128, 192), "R6 masked index 0xF5 -> 5");
        drive(0, 1, 2'd2, 8'd0); idle();
        chk(int'(host_rdata), 8'h0F, "R6 mask readback");

        // R8: read back with wrap
        drive(1, 0, 2'd3, 8'd254);
        for (int e = 254; e < 256; e++) begin
            drive(0, 1, 2'd1, 8'd0); idle();
            chk(int'(host_rdata), ((fill_rgb(e) >> 12) & 63) << 2, "R8 red");
            drive(0, 1, 2'd1, 8'd0); idle();
            chk(int'(host_rdata), ((fill_rgb(e) >> 6) & 63) << 2, "R8 green");
            drive(0, 1, 2'd1, 8'd0); idle();
            chk(int'(host_rdata), (fill_rgb(e) & 63) << 2, "R8 blue");
        end
        drive(0, 1, 2'd1, 8'd0); idle();
        chk(int'(host_rdata), 8'hFC, "R8 wrapped red of entry 0");
        drive(0, 1, 2'd1, 8'd0); idle();
        chk(int'(host_rdata), 8'h00, "R8 wrapped green of entry 0");
        drive(0, 1, 2'd1, 8'd0); idle();
        chk(int'(host_rdata), 8'h80, "R8 wrapped blue of entry 0");

        // R9: read ignored during write, hold, index reads give 0
        drive(1, 1, 2'd2, 8'hFF); idle();
        chk(int'(host_rdata), 8'h80, "R9 read ignored while writing");
        idle();
        chk(int'(host_rdata), 8'h80, "R9 hold without read");
        drive(0, 1, 2'd0, 8'd0); idle();
        chk(int'(host_rdata), 0, "R9 read of write-entry register");

        // R10: interleaved write and read sequences
        drive(1, 0, 2'd3, 8'd10);
        drive(1, 0, 2'd0, 8'd20);
        drive(1, 0, 2'd1, 8'h04);
        drive(0, 1, 2'd1, 8'd0); idle();
        chk(int'(host_rdata), ((fill_rgb(10) >> 12) & 63) << 2, "R10 read red mid-write");
        drive(0, 1, 2'd1, 8'd0); idle();
        chk(int'(host_rdata), ((fill_rgb(10) >> 6) & 63) << 2, "R10 read green mid-write");
        drive(0, 1, 2'd1, 8'd0); idle();
        chk(int'(host_rdata), (fill_rgb(10) & 63) << 2, "R10 read blue mid-write");
        drive(1, 0, 2'd1, 8'h08); drive(1, 0, 2'd1, 8'h0C);
        pix_idx = 8'd20; idle(); idle();
        chk(int'(pix_rgb), rgb_of(4, 8, 12), "R10 pending write completed");
        drive(0, 1, 2'd1, 8'd0); idle();
        chk(int'(host_rdata), ((fill_rgb(11) >> 12) & 63) << 2, "R10 read pointer moved to 11");

        repeat (3) idle();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule